// File: doc/BRIEF.md
# Round-Trip Link Delay Meter

This block measures how long a signal takes to travel one way to the neighbouring node on a ring link. On a start request it fires a one-cycle probe strobe toward the transmit side. It then counts system clock ticks (10 ns each at 100 MHz) until the neighbour's echo shows up as a rising receive data-valid. The probe is repeated 1, 2, 4 or 8 times and the tick counts are summed. Each new probe waits until receive data-valid is low again.

When the last echo is in, the sum is divided by twice the sample count with a shift only. The result is a 28-bit unsigned one-way delay with 4 fractional bits: 24 bits of whole 10 ns ticks and 4 bits of sixteenths. The block also adds this delay to a base delay captured at start, which is the delay already gathered upstream. The sum is ready to be forwarded to the next node.

If an echo does not come within a parameterised number of ticks, the measurement is abandoned. An error flag is raised and no completion pulse is given.

Top module: `link_delay_meter`

## Requirements
- R1: After a synchronous reset, `probe_o`, `done_o` and `timeout_o` are 0, and `delay_o` and `total_delay_o` are 0.
- R2: `probe_o` is high for exactly one cycle per probe. The first probe of a measurement follows a start that is accepted while idle.
- R3: A probe is never issued while `rx_valid_i` is high. After `rx_valid_i` is sampled low at an edge, the next pending probe is visible in the following cycle.
- R4: The round-trip count of a sample is k when the probe is visible in cycle c and `rx_valid_i` is first high in cycle c+k (k ≥ 1).
- R5: `samples_sel_i` values 0, 1, 2 and 3 select exactly 1, 2, 4 and 8 probes per measurement.
- R6: `delay_o` equals the floor of (sum of round-trip counts × 16) / (2 × sample count), as a 28-bit value with bits [3:0] as the fraction.
- R7: `total_delay_o` equals the `base_delay_i` captured at start plus `delay_o`, modulo 2^28.
- R8: `done_o` pulses high for one cycle, two cycles after the cycle in which the last echo is first high. The results then hold until the next start.
- R9: If no echo arrives by count TIMEOUT_TICKS, `timeout_o` rises one cycle later. In that case no done pulse and no further probe follow. An echo at exactly k = TIMEOUT_TICKS is still accepted.
- R10: An accepted start clears `delay_o`, `total_delay_o` and `timeout_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock, one count tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a measurement when idle |
| samples_sel_i | input | 2 | Number of probes as log2: 0→1, 1→2, 2→4, 3→8 |
| rx_valid_i | input | 1 | Receive data-valid; its rising edge marks an echo |
| base_delay_i | input | 28 | Upstream 24.4 delay, captured at start |
| probe_o | output | 1 | One-cycle strobe requesting a probe transmission |
| delay_o | output | 28 | Measured one-way delay, 24.4 fixed point |
| total_delay_o | output | 28 | Captured base delay plus measured delay |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Set when an echo failed to arrive; cleared by start |

## Verification
After a start, the cleared outputs are due in the next cycle. The first probe is due one cycle after `rx_valid_i` is seen low. `done_o`, together with the final `delay_o` and `total_delay_o`, is due exactly two cycles after the last echo cycle. `timeout_o` is due one cycle after the probe cycle plus TIMEOUT_TICKS.

The bench drives on falling edges and samples on falling edges. It counts whole cycles from the probe it observes, so every check lands in the single cycle where the result must first appear. It also checks the cycles just before and after, so a result that comes early, late or lasts too long is reported. Echo latencies of 1 and of exactly the timeout limit cover both ends of the count range.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

    localparam int SEL_W   = 2;
    localparam int SMP_W   = (1 << SEL_W) - 1;
    localparam int MAX_LOG = (1 << SEL_W) - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_LOW,
        ST_SEND,
        ST_COUNT,
        ST_FINISH
    } ldm_state_e;

    typedef struct packed {
        logic clr;
        logic probe;
        logic run;
        logic add;
        logic finish;
    } ldm_ctrl_t;

    function automatic logic [SMP_W-1:0] last_index(input logic [SEL_W-1:0] sel);
        return SMP_W'((1 << sel) - 1);
    endfunction

endpackage

// File: rtl/ldm_tick_counter.sv
module ldm_tick_counter #(
    parameter int LIMIT = 1 << 20,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= CNT_W'(1);
        else if (run_i)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign count_o   = cnt_q;
    assign expired_o = (cnt_q == CNT_W'(LIMIT));

    p_count_bounded_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(LIMIT));

endmodule

// File: rtl/ldm_sequencer.sv
module ldm_sequencer
    import ldm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             rx_valid_i,
    input  logic             expired_i,
    output ldm_ctrl_t        ctrl_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             probe_o,
    output logic             done_o,
    output logic             timeout_o
);

    ldm_state_e       state_q, state_d;
    logic             rx_q;
    logic             rx_rise;
    logic [SMP_W-1:0] smp_q;
    logic [SEL_W-1:0] sel_q;
    logic             done_q;
    logic             tmo_q;
    logic             abort;
    logic             last;

    assign rx_rise = rx_valid_i & ~rx_q;
    assign last    = (smp_q == last_index(sel_q));

    always_comb begin
        state_d = state_q;
        ctrl_o  = '0;
        abort   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_o.clr = 1'b1;
                    state_d    = ST_WAIT_LOW;
                end
            end
            ST_WAIT_LOW: begin
                if (!rx_valid_i)
                    state_d = ST_SEND;
            end
            ST_SEND: begin
                ctrl_o.probe = 1'b1;
                state_d      = ST_COUNT;
            end
            ST_COUNT: begin
                if (rx_rise) begin
                    ctrl_o.add = 1'b1;
                    state_d    = last ? ST_FINISH : ST_WAIT_LOW;
                end else if (expired_i) begin
                    abort   = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    ctrl_o.run = 1'b1;
                end
            end
            ST_FINISH: begin
                ctrl_o.finish = 1'b1;
                state_d       = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rx_q    <= 1'b0;
            smp_q   <= '0;
            sel_q   <= '0;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rx_q    <= rx_valid_i;
            done_q  <= ctrl_o.finish;
            if (ctrl_o.clr) begin
                smp_q <= '0;
                sel_q <= sel_i;
                tmo_q <= 1'b0;
            end else begin
                if (ctrl_o.add && !last)
                    smp_q <= smp_q + SMP_W'(1);
                if (abort)
                    tmo_q <= 1'b1;
            end
        end
    end

    assign sel_o     = sel_q;
    assign probe_o   = (state_q == ST_SEND);
    assign done_o    = done_q;
    assign timeout_o = tmo_q;

    p_probe_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        probe_o |=> !probe_o);

    p_probe_after_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(probe_o) |-> !$past(rx_valid_i));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_no_done_on_timeout_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> !done_o);

endmodule

// File: rtl/ldm_accumulator.sv
module ldm_accumulator
    import ldm_pkg::*;
#(
    parameter int CNT_W  = 21,
    parameter int ACC_W  = CNT_W + MAX_LOG,
    parameter int DLY_W  = 28,
    parameter int FRAC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             add_i,
    input  logic             finish_i,
    input  logic [CNT_W-1:0] sample_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [DLY_W-1:0] base_i,
    output logic [DLY_W-1:0] delay_o,
    output logic [DLY_W-1:0] total_o
);

    localparam int WIDE = (ACC_W + FRAC_W > DLY_W) ? ACC_W + FRAC_W : DLY_W;

    logic [ACC_W-1:0] acc_q;
    logic [DLY_W-1:0] base_q;
    logic [DLY_W-1:0] delay_q;
    logic [DLY_W-1:0] total_q;
    logic [WIDE-1:0]  acc_ext;
    logic [WIDE-1:0]  scaled;
    logic [DLY_W-1:0] delay_d;

    assign acc_ext = WIDE'(acc_q);
    assign scaled  = (acc_ext << FRAC_W) >> (int'(sel_i) + 1);
    assign delay_d = scaled[DLY_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            base_q  <= '0;
            delay_q <= '0;
            total_q <= '0;
        end else if (clr_i) begin
            acc_q   <= '0;
            base_q  <= base_i;
            delay_q <= '0;
            total_q <= '0;
        end else begin
            if (add_i)
                acc_q <= acc_q + ACC_W'(sample_i);
            if (finish_i) begin
                delay_q <= delay_d;
                total_q <= base_q + delay_d;
            end
        end
    end

    assign delay_o = delay_q;
    assign total_o = total_q;

    p_acc_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
        add_i |=> acc_q >= $past(acc_q));

    p_hold_results_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !finish_i) |=> $stable(delay_q) && $stable(total_q));

endmodule

// File: rtl/link_delay_meter.sv
module link_delay_meter
    import ldm_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 1 << 20,
    parameter int DLY_W         = 28,
    parameter int FRAC_W        = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       samples_sel_i,
    input  logic             rx_valid_i,
    input  logic [27:0]      base_delay_i,
    output logic             probe_o,
    output logic [27:0]      delay_o,
    output logic [27:0]      total_delay_o,
    output logic             done_o,
    output logic             timeout_o
);

    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam int ACC_W = CNT_W + MAX_LOG;

    ldm_ctrl_t        ctrl;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] count;
    logic             expired;

    ldm_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .sel_i      (samples_sel_i),
        .rx_valid_i (rx_valid_i),
        .expired_i  (expired),
        .ctrl_o     (ctrl),
        .sel_o      (sel),
        .probe_o    (probe_o),
        .done_o     (done_o),
        .timeout_o  (timeout_o)
    );

    ldm_tick_counter #(
        .LIMIT (TIMEOUT_TICKS),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load_i    (ctrl.probe),
        .run_i     (ctrl.run),
        .count_o   (count),
        .expired_o (expired)
    );

    ldm_accumulator #(
        .CNT_W  (CNT_W),
        .ACC_W  (ACC_W),
        .DLY_W  (DLY_W),
        .FRAC_W (FRAC_W)
    ) u_acc (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (ctrl.clr),
        .add_i    (ctrl.add),
        .finish_i (ctrl.finish),
        .sample_i (count),
        .sel_i    (sel),
        .base_i   (base_delay_i),
        .delay_o  (delay_o),
        .total_o  (total_delay_o)
    );

endmodule

// File: tb/link_delay_meter_test.sv
module link_delay_meter_test;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  samples_sel_i = '0;
    logic        rx_valid_i = 1'b0;
    logic [27:0] base_delay_i = '0;
    logic        probe_o;
    logic [27:0] delay_o;
    logic [27:0] total_delay_o;
    logic        done_o;
    logic        timeout_o;

    int checks = 0;
    int errors = 0;
    int lat_a[8];
    int hold_a[8];

    always #(CLK_PERIOD / 2) clk = ~clk;

    link_delay_meter #(.TIMEOUT_TICKS(TMO)) uut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .samples_sel_i (samples_sel_i),
        .rx_valid_i    (rx_valid_i),
        .base_delay_i  (base_delay_i),
        .probe_o       (probe_o),
        .delay_o       (delay_o),
        .total_delay_o (total_delay_o),
        .done_o        (done_o),
        .timeout_o     (timeout_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_start(input logic [1:0] sel, input logic [27:0] base);
        @(negedge clk);
        start_i = 1'b1;
        samples_sel_i = sel;
        base_delay_i = base;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 delay cleared", delay_o, 0);
        chk("R10 total cleared", total_delay_o, 0);
        chk("R10 timeout cleared", timeout_o, 0);
    endtask

    task automatic wait_probe(input string req);
        int w = 0;
        while (!probe_o && w < 200) begin
            if (rx_valid_i) chk({req, " R3 no probe while rx high"}, probe_o, 0);
            @(negedge clk);
            w++;
        end
        chk({req, " probe seen"}, probe_o, 1);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 probe", probe_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 timeout", timeout_o, 0);
        chk("R1 delay", delay_o, 0);
        chk("R1 total", total_delay_o, 0);
    endtask

    task automatic t_measure(input string tag, input logic [1:0] sel, input logic [27:0] base);
        int n = 1 << sel;
        longint sum = 0;
        logic [27:0] exp_d;
        logic [27:0] exp_t;
        do_start(sel, base);
        for (int i = 0; i < n; i++) begin
            wait_probe({tag, " R2"});
            @(negedge clk);
            chk({tag, " R2 probe single cycle"}, probe_o, 0);
            for (int j = 1; j < lat_a[i]; j++) begin
                @(negedge clk);
                chk({tag, " R2 no extra probe"}, probe_o, 0);
            end
            rx_valid_i = 1'b1;
            sum += lat_a[i];
            if (i == n - 1) begin
                exp_d = 28'((sum * 16) / (2 * n));
                exp_t = base + exp_d;
                @(negedge clk);
                chk({tag, " R8 done not early"}, done_o, 0);
                @(negedge clk);
                chk({tag, " R8 done due"}, done_o, 1);
                chk({tag, " R4 R6 delay"}, delay_o, exp_d);
                chk({tag, " R7 total"}, total_delay_o, exp_t);
                @(negedge clk);
                chk({tag, " R8 done one cycle"}, done_o, 0);
                rx_valid_i = 1'b0;
                for (int j = 0; j < 6; j++) begin
                    @(negedge clk);
                    chk({tag, " R5 no probe after last sample"}, probe_o, 0);
                end
                chk({tag, " R8 delay held"}, delay_o, exp_d);
                chk({tag, " R8 total held"}, total_delay_o, exp_t);
            end else begin
                for (int j = 0; j < hold_a[i]; j++) begin
                    @(negedge clk);
                    chk({tag, " R3 no probe while echo high"}, probe_o, 0);
                end
                rx_valid_i = 1'b0;
                @(negedge clk);
                chk({tag, " R3 probe one cycle after low"}, probe_o, 1);
            end
        end
    endtask

    task automatic t_rx_high_at_start;
        rx_valid_i = 1'b1;
        do_start(2'd0, 28'd3);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk("R3 held off while rx high", probe_o, 0);
        end
        rx_valid_i = 1'b0;
        @(negedge clk);
        chk("R3 probe after rx low", probe_o, 1);
        @(negedge clk);
        rx_valid_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 done k=1", done_o, 1);
        chk("R4 delay k=1", delay_o, 28'd8);
        chk("R7 total k=1", total_delay_o, 28'd11);
        rx_valid_i = 1'b0;
    endtask

    task automatic t_timeout;
        do_start(2'd1, 28'd5);
        wait_probe("R9");
        repeat (TMO) @(negedge clk);
        chk("R9 timeout not early", timeout_o, 0);
        @(negedge clk);
        chk("R9 timeout due", timeout_o, 1);
        chk("R9 no done", done_o, 0);
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            chk("R9 no probe after timeout", probe_o | done_o, 0);
        end
        chk("R9 delay untouched", delay_o, 0);
        chk("R9 timeout holds", timeout_o, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8: got hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();

        lat_a[0] = 5;
        t_measure("single", 2'd0, 28'd0);

        lat_a[0] = 3; lat_a[1] = 4; hold_a[0] = 2;
        t_measure("pair", 2'd1, 28'd100);

        lat_a[0] = 5; lat_a[1] = 6; lat_a[2] = 7; lat_a[3] = 9;
        hold_a[0] = 1; hold_a[1] = 7; hold_a[2] = 3;
        t_measure("quad", 2'd2, 28'h0000123);

        for (int i = 0; i < 8; i++) begin
            lat_a[i]  = i + 1;
            hold_a[i] = (i % 3) + 1;
        end
        t_measure("octet wrap", 2'd3, 28'hFFFFFFF);

        t_rx_high_at_start();

        t_timeout();

        lat_a[0] = TMO;
        t_measure("R9 echo at limit", 2'd0, 28'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule